// File: doc/BRIEF.md
# Encrypting Memory Integrity Engine

This engine sits between an on-chip cache and the controller of an untrusted external memory. It keeps each off-chip line both secret and checked, and it does this in one pass. A write request carries a 96-bit payload. The engine joins that payload to a 32-bit redundancy value that it builds on chip. It sends the 128-bit block to an external block cipher for encryption and then stores the ciphertext at the line's address. A read fetches the ciphertext and has the cipher decrypt it. The engine then compares the recovered redundancy field with a reference that never leaves the chip. No separate tag is computed, and no tag is stored.

The redundancy value joins the line address to a per-line write counter. The counters live in an on-chip table. Because of this, three kinds of tampered block all fail the comparison: a random word (spoofing), a block copied from another line (splicing), and an older copy of the same line (replay). When the check fails, the engine returns zero data with the OK flag low and sets a sticky error bit. The cipher and the memory are reached through req/ack handshakes, and only one operation is in flight at any time.

The sequencer states are ST_IDLE, ST_WENC, ST_WMEM, ST_RMEM, ST_RDEC and ST_RESP.
- Write path: ST_IDLE goes to ST_WENC when a write is accepted, ST_WENC goes to ST_WMEM on cipher ack, and ST_WMEM goes to ST_RESP on memory ack.
- Read path: ST_IDLE goes to ST_RMEM when a read is accepted, ST_RMEM goes to ST_RDEC on memory ack, and ST_RDEC goes to ST_RESP on cipher ack.
- ST_RESP always returns to ST_IDLE after one cycle.

Top module: `mie_engine`

## Requirements
- R1: On a write, the engine first presents `{payload, RV}` to the cipher with `cph_decrypt`=0. Only after the cipher acks does it issue a memory write of the returned ciphertext to `mem_addr` = the line address.
- R2: RV is 32 bits. Bits [31:16] hold the line address, zero-extended. Bits [15:0] hold the line's write counter. The payload occupies block bits [127:32] and RV occupies bits [31:0].
- R3: Every counter is 0 after reset. A completed write increments the counter of its own line by one, and the encryption uses the incremented value. The counters of all other lines are unchanged.
- R4: On a read, the engine first fetches from memory. It then presents the fetched word to the cipher with `cph_decrypt`=1.
- R5: If bits [31:0] of the decrypted block equal the reference RV (line address with the current counter), then `rsp_ok`=1 and `rsp_rdata` = bits [127:32] of the decrypted block.
- R6: If those bits do not match, then `rsp_ok`=0 and `rsp_rdata` is all zeros. This covers spoofed, spliced and replayed blocks.
- R7: `err_sticky` is set by a failed read and stays set until `err_clr` is asserted. If a failed read and `err_clr` occur in the same cycle, the set wins.
- R8: `cph_req` and `mem_req` are never high together. Each request is held, with stable data, until its ack arrives. `req_ready` is high only while the engine is idle.
- R9: Each accepted access produces exactly one single-cycle `rsp_valid` pulse. Writes report `rsp_ok`=1.
- R10: After reset, `req_ready`=1, and `cph_req`, `mem_req`, `rsp_valid` and `err_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cache access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | PAY_W | Write payload |
| req_ready | output | 1 | Engine idle and accepting a request |
| rsp_valid | output | 1 | Completion pulse |
| rsp_ok | output | 1 | Integrity check passed (always 1 for writes) |
| rsp_rdata | output | PAY_W | Read payload, zero on failure |
| cph_req | output | 1 | Cipher operation request |
| cph_decrypt | output | 1 | 1 = decrypt, 0 = encrypt |
| cph_din | output | PAY_W+RV_W | Block sent to the cipher |
| cph_ack | input | 1 | Cipher result valid |
| cph_dout | input | PAY_W+RV_W | Cipher result |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory line address |
| mem_wdata | output | PAY_W+RV_W | Ciphertext to store |
| mem_ack | input | 1 | Memory access done |
| mem_rdata | input | PAY_W+RV_W | Fetched ciphertext |
| err_clr | input | 1 | Clears the sticky error bit |
| err_sticky | output | 1 | Sticky integrity failure flag |

## Verification
The bench writes every line and reads every line back, with cipher and memory latencies of zero to three cycles. This shows that the encrypt and decrypt ordering does not depend on handshake timing. It then rewrites some lines several times, and each stored word is compared with an arithmetic encryption of the expected payload, address and counter. This tells apart a counter that bumps the wrong line, or bumps at the wrong moment, from a correct one. Separate tampering patterns then change the stored ciphertext: a word copied from another line, a stale copy of the same line, and a single flipped bit inside the redundancy field. Each pattern shows whether the address half and the counter half of the reference are each really compared. Finally, sequences of clear, good read and failed read separate sticky behaviour from a plain per-access flag, and show that a set in the same cycle as a clear takes priority.

// File: rtl/mie_pkg.sv
package mie_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WENC,
        ST_WMEM,
        ST_RMEM,
        ST_RDEC,
        ST_RESP
    } mie_state_e;
endpackage

// File: rtl/mie_rv_gen.sv
module mie_rv_gen #(
    parameter int ADDR_W = 4,
    parameter int RV_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] line,
    input  logic              use_next,
    input  logic              bump,
    output logic [RV_W-1:0]   rv
);
    localparam int AF_W  = RV_W / 2;
    localparam int CTR_W = RV_W - AF_W;
    localparam int LINES = 1 << ADDR_W;

    logic [CTR_W-1:0] ctr_tab [LINES];
    logic [CTR_W-1:0] cur;
    logic [CTR_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) ctr_tab[i] <= '0;
        end else if (bump) begin
            ctr_tab[line] <= ctr_tab[line] + CTR_W'(1);
        end
    end

    always_comb begin
        cur = ctr_tab[line];
        sel = use_next ? cur + CTR_W'(1) : cur;
        rv  = {AF_W'(line), sel};
    end

    // R3: a committed write advances its own line's counter by exactly one
    a_r3_bump_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> ctr_tab[$past(line)] == $past(cur) + CTR_W'(1));
endmodule

// File: rtl/mie_check.sv
module mie_check #(
    parameter int PAY_W = 96,
    parameter int RV_W  = 32
) (
    input  logic [PAY_W+RV_W-1:0] blk,
    input  logic [RV_W-1:0]       rv_ref,
    output logic                  match,
    output logic [PAY_W-1:0]      payload
);
    always_comb begin
        match   = (blk[RV_W-1:0] == rv_ref);
        payload = match ? blk[PAY_W+RV_W-1:RV_W] : '0;
    end
endmodule

// File: rtl/mie_seq.sv
module mie_seq
    import mie_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int PAY_W  = 96,
    parameter int RV_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [PAY_W-1:0]      req_wdata,
    output logic                  req_ready,
    input  logic [RV_W-1:0]       rv,
    input  logic                  match,
    output logic [ADDR_W-1:0]     line_q,
    output logic                  wr_q,
    output logic                  bump,
    output logic [PAY_W+RV_W-1:0] blk_q,
    output logic                  resp,
    output logic                  cph_req,
    output logic                  cph_decrypt,
    output logic [PAY_W+RV_W-1:0] cph_din,
    input  logic                  cph_ack,
    input  logic [PAY_W+RV_W-1:0] cph_dout,
    output logic                  mem_req,
    output logic                  mem_we,
    input  logic                  mem_ack,
    input  logic [PAY_W+RV_W-1:0] mem_rdata,
    input  logic                  err_clr,
    output logic                  err_sticky
);
    mie_state_e state, nxt;
    logic [PAY_W-1:0] pay_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = req_write ? ST_WENC : ST_RMEM;
            ST_WENC: if (cph_ack)   nxt = ST_WMEM;
            ST_WMEM: if (mem_ack)   nxt = ST_RESP;
            ST_RMEM: if (mem_ack)   nxt = ST_RDEC;
            ST_RDEC: if (cph_ack)   nxt = ST_RESP;
            ST_RESP:                nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready   = 1'b0;
        cph_req     = 1'b0;
        cph_decrypt = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        resp        = 1'b0;
        bump        = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_WENC: cph_req = 1'b1;
            ST_WMEM: begin mem_req = 1'b1; mem_we = 1'b1; bump = mem_ack; end
            ST_RMEM: mem_req = 1'b1;
            ST_RDEC: begin cph_req = 1'b1; cph_decrypt = 1'b1; end
            ST_RESP: resp = 1'b1;
            default: ;
        endcase
        cph_din = cph_decrypt ? blk_q : {pay_q, rv};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            wr_q   <= 1'b0;
            pay_q  <= '0;
            blk_q  <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                line_q <= req_addr;
                wr_q   <= req_write;
                pay_q  <= req_wdata;
            end
            if ((state == ST_WENC || state == ST_RDEC) && cph_ack) blk_q <= cph_dout;
            if (state == ST_RMEM && mem_ack)                      blk_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             err_sticky <= 1'b0;
        else if (state == ST_RESP && !wr_q && !match) err_sticky <= 1'b1;
        else if (err_clr)                       err_sticky <= 1'b0;
    end

    // R8: cipher request held with stable operands until acknowledged
    a_r8_cph_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req && !cph_ack |=> cph_req && $stable(cph_din) && $stable(cph_decrypt));
    // R8: memory request held until acknowledged
    a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we));
    // R4: decryption starts only right after a memory fetch completes
    a_r4_dec_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cph_req) && cph_decrypt |-> $past(mem_req && mem_ack && !mem_we));
    // R1: memory write starts only right after an encryption completes
    a_r1_store_after_enc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && mem_we |-> $past(cph_req && cph_ack && !cph_decrypt));
endmodule

// File: rtl/mie_engine.sv
module mie_engine #(
    parameter int ADDR_W = 4,
    parameter int PAY_W  = 96,
    parameter int RV_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [PAY_W-1:0]      req_wdata,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic                  rsp_ok,
    output logic [PAY_W-1:0]      rsp_rdata,
    output logic                  cph_req,
    output logic                  cph_decrypt,
    output logic [PAY_W+RV_W-1:0] cph_din,
    input  logic                  cph_ack,
    input  logic [PAY_W+RV_W-1:0] cph_dout,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [PAY_W+RV_W-1:0] mem_wdata,
    input  logic                  mem_ack,
    input  logic [PAY_W+RV_W-1:0] mem_rdata,
    input  logic                  err_clr,
    output logic                  err_sticky
);
    localparam int BLK_W = PAY_W + RV_W;

    logic [ADDR_W-1:0] line_q;
    logic              wr_q, bump, match, resp;
    logic [RV_W-1:0]   rv;
    logic [BLK_W-1:0]  blk_q;
    logic [PAY_W-1:0]  chk_pay;

    mie_rv_gen #(.ADDR_W(ADDR_W), .RV_W(RV_W)) rv_i (
        .clk(clk), .rst_n(rst_n), .line(line_q), .use_next(wr_q),
        .bump(bump), .rv(rv));

    mie_check #(.PAY_W(PAY_W), .RV_W(RV_W)) chk_i (
        .blk(blk_q), .rv_ref(rv), .match(match), .payload(chk_pay));

    mie_seq #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .RV_W(RV_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rv(rv), .match(match), .line_q(line_q), .wr_q(wr_q), .bump(bump),
        .blk_q(blk_q), .resp(resp), .cph_req(cph_req), .cph_decrypt(cph_decrypt),
        .cph_din(cph_din), .cph_ack(cph_ack), .cph_dout(cph_dout),
        .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .err_clr(err_clr), .err_sticky(err_sticky));

    assign mem_addr  = line_q;
    assign mem_wdata = blk_q;
    assign rsp_valid = resp;
    assign rsp_ok    = wr_q | match;
    assign rsp_rdata = wr_q ? '0 : chk_pay;

    // R6: a failed access never returns data
    a_r6_zero_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ok |-> rsp_rdata == '0);
    // R7: the error flag holds until cleared
    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky && !err_clr |=> err_sticky);
    // R7: a failed read response raises the flag
    a_r7_set_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ok |=> err_sticky);
    // R9: completion is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R8: only one external operation in flight, none while accepting
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cph_req && mem_req) && !(req_ready && (cph_req || mem_req)));
endmodule

// File: tb/mie_engine_tb_top.sv
module mie_engine_tb_top;
    localparam int ADDR_W = 4;
    localparam int PAY_W  = 96;
    localparam int RV_W   = 32;
    localparam int BLK_W  = PAY_W + RV_W;
    localparam int LINES  = 1 << ADDR_W;
    localparam logic [BLK_W-1:0] KEY = 128'h3C6E_F372_A54F_F53A_510E_527F_9B05_688C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              req_valid = 1'b0, req_write = 1'b0, err_clr = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [PAY_W-1:0]  req_wdata = '0;
    logic              req_ready, rsp_valid, rsp_ok, err_sticky;
    logic [PAY_W-1:0]  rsp_rdata;
    logic              cph_req, cph_decrypt, mem_req, mem_we;
    logic              cph_ack, mem_ack;
    logic [BLK_W-1:0]  cph_din, cph_dout, mem_wdata, mem_rdata;
    logic [ADDR_W-1:0] mem_addr;

    mie_engine #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .RV_W(RV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
        .cph_req(cph_req), .cph_decrypt(cph_decrypt), .cph_din(cph_din),
        .cph_ack(cph_ack), .cph_dout(cph_dout), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .err_clr(err_clr), .err_sticky(err_sticky));

    function automatic logic [BLK_W-1:0] enc(input logic [BLK_W-1:0] x);
        return {x[BLK_W-14:0], x[BLK_W-1:BLK_W-13]} ^ KEY;
    endfunction
    function automatic logic [BLK_W-1:0] dec(input logic [BLK_W-1:0] y);
        logic [BLK_W-1:0] z;
        z = y ^ KEY;
        return {z[12:0], z[BLK_W-1:13]};
    endfunction

    int cph_lat = 0, mem_lat = 0, cph_cnt = 0, mem_cnt = 0;
    logic [BLK_W-1:0] mem_arr [LINES];
    logic              tamper_en = 1'b0;
    logic [ADDR_W-1:0] tamper_addr = '0;
    logic [BLK_W-1:0]  tamper_data = '0;
    int overlap = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cph_ack <= 1'b0; cph_cnt <= 0; cph_dout <= '0;
        end else if (cph_ack) begin
            cph_ack <= 1'b0; cph_cnt <= 0;
        end else if (cph_req) begin
            if (cph_cnt >= cph_lat) begin
                cph_ack  <= 1'b1;
                cph_dout <= cph_decrypt ? dec(cph_din) : enc(cph_din);
            end else cph_cnt <= cph_cnt + 1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_cnt <= 0; mem_rdata <= '0;
            for (int i = 0; i < LINES; i++) mem_arr[i] <= '0;
        end else begin
            if (tamper_en) mem_arr[tamper_addr] <= tamper_data;
            if (mem_ack) begin
                mem_ack <= 1'b0; mem_cnt <= 0;
            end else if (mem_req) begin
                if (mem_cnt >= mem_lat) begin
                    mem_ack <= 1'b1;
                    if (mem_we) mem_arr[mem_addr] <= mem_wdata;
                    else        mem_rdata <= mem_arr[mem_addr];
                end else mem_cnt <= mem_cnt + 1;
            end
        end
        if (rst_n && cph_req && mem_req) overlap <= overlap + 1;
    end

    int n_chk = 0, n_fail = 0;
    logic [15:0] ctr_m [LINES];

    task automatic check(input string req, input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [PAY_W-1:0] pat(input int a, input int g);
        return {32'(a * 32'h9E37_79B9 + g), 32'(32'hA5A5_0000 ^ (a << 8) ^ g), 32'(g * 7 + a)};
    endfunction

    task automatic wait_rsp(output logic ok, output logic [PAY_W-1:0] d);
        int t = 0;
        ok = 1'b0; d = '0;
        while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
        if (!rsp_valid) begin
            check("R9 response timeout", 0, 1);
        end else begin
            ok = rsp_ok; d = rsp_rdata;
        end
    endtask

    task automatic issue(input logic w, input int a, input logic [PAY_W-1:0] p);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = ADDR_W'(a); req_wdata = p;
        @(negedge clk);
        req_valid = 1'b0;
        if (!w || 1) begin end
    endtask

    task automatic do_write(input int a, input logic [PAY_W-1:0] p);
        logic ok; logic [PAY_W-1:0] d;
        issue(1'b1, a, p);
        wait_rsp(ok, d);
        check("R9 write rsp_ok", BLK_W'(ok), 1);
        ctr_m[a] = ctr_m[a] + 16'd1;
        @(negedge clk);
        // R1 R2 R3: stored word is the encryption of {payload, addr16, counter}
        check("R1/R2/R3 stored ciphertext", mem_arr[a], enc({p, 16'(a), ctr_m[a]}));
    endtask

    task automatic do_read(input int a, input string tag);
        logic ok; logic [PAY_W-1:0] d;
        logic [BLK_W-1:0] pl;
        logic good;
        pl = dec(mem_arr[a]);
        good = (pl[RV_W-1:0] == {16'(a), ctr_m[a]});
        issue(1'b0, a, '0);
        wait_rsp(ok, d);
        check({tag, " rsp_ok"}, BLK_W'(ok), BLK_W'(good));
        check({tag, " rsp_rdata"}, BLK_W'(d), good ? BLK_W'(pl[BLK_W-1:RV_W]) : '0);
    endtask

    task automatic tamper(input int a, input logic [BLK_W-1:0] v);
        @(negedge clk);
        tamper_en = 1'b1; tamper_addr = ADDR_W'(a); tamper_data = v;
        @(negedge clk);
        tamper_en = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) ctr_m[i] = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 req_ready", BLK_W'(req_ready), 1);
        check("R10 cph_req/mem_req", BLK_W'({cph_req, mem_req}), 0);
        check("R10 rsp_valid", BLK_W'(rsp_valid), 0);
        check("R10 err_sticky", BLK_W'(err_sticky), 0);

        // fill every line with varied handshake latency
        for (int a = 0; a < LINES; a++) begin
            cph_lat = a % 4; mem_lat = (a / 4) % 4;
            do_write(a, pat(a, 1));
        end
        // R8 busy: ready drops while an access is in flight
        issue(1'b0, 3, '0);
        check("R8 req_ready low while busy", BLK_W'(req_ready), 0);
        begin
            logic ok; logic [PAY_W-1:0] d;
            wait_rsp(ok, d);
            check("R5 line 3 ok", BLK_W'(ok), 1);
        end
        // R4 R5: read back all lines
        for (int a = 0; a < LINES; a++) begin
            cph_lat = (a + 1) % 4; mem_lat = (a + 2) % 4;
            do_read(a, "R4/R5 readback");
        end
        // R3: rewrites, line-local counters
        for (int a = LINES - 1; a >= 0; a--)
            for (int k = 0; k <= a % 3; k++) do_write(a, pat(a, 10 + k));
        for (int a = 0; a < LINES; a++) do_read(a, "R3/R5 after rewrite");
        check("R7 no error yet", BLK_W'(err_sticky), 0);

        // R6 replay of a stale copy
        begin
            logic [BLK_W-1:0] old5;
            old5 = mem_arr[5];
            do_write(5, pat(5, 99));
            tamper(5, old5);
            do_read(5, "R6 replay");
        end
        @(negedge clk);
        check("R7 set after replay", BLK_W'(err_sticky), 1);
        do_read(7, "R5 good read after fail");
        check("R7 stays set across good read", BLK_W'(err_sticky), 1);
        clear_err();
        check("R7 cleared", BLK_W'(err_sticky), 0);

        // R6 splice from another line
        tamper(9, mem_arr[2]);
        do_read(9, "R6 splice");
        @(negedge clk);
        check("R7 set after splice", BLK_W'(err_sticky), 1);
        clear_err();
        // R6 spoof: flip a ciphertext bit landing in the redundancy field
        tamper(12, mem_arr[12] ^ (BLK_W'(1) << 20));
        do_read(12, "R6 spoof");
        // R7 set wins over clear in the same cycle
        clear_err();
        @(negedge clk); err_clr = 1'b1;
        do_read(9, "R6 splice reread");
        @(negedge clk); err_clr = 1'b0;
        check("R7 set wins over clear", BLK_W'(err_sticky), 1);
        // recovery after rewrite
        do_write(9, pat(9, 5));
        do_read(9, "R5 rewritten line");

        check("R8 no cipher/memory overlap", BLK_W'(overlap), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule